// File: doc/BRIEF.md
# Codec Configuration Register Loader

This block holds the six byte-wide settings of a block error-correction codec and fills them while the codec reset is held low. During that reset window, every falling edge of the active-low input strobe copies the data bus into the next setting register. The order is fixed and there is no address. The settings drive the codec datapath directly and have no path back to software. To change any one setting, the whole reset-and-reload sequence must be run again.

The block also watches the timing of reset against the strobes. It flags strobes that come too soon after reset falls, a release of reset that comes too soon after the last setting byte, surplus strobes, and a window that ends before all six bytes arrived. After reset is released it keeps the datapath write enable closed for two clocks. It then raises a ready indication, but only if the load was complete. Every flag stays set until the next reset window opens.

Top module: `codec_cfg_loader`

## Requirements
- R1: While reset is low, accepted strobes load the data bus into the settings in this fixed order. Slot 0 is the erasure multiplier, slot 1 the error threshold, slot 2 the check-byte count, slot 3 the message-byte count, slot 4 the block length and slot 5 the control byte. Each register shows its new value one clock after the strobe edge is sampled.
- R2: One byte is loaded per strobe pulse. A strobe held low for several clocks loads only once, on its falling edge.
- R3: Strobe edges after the sixth in the same window are ignored. Every register keeps its value and the sticky `overflow_o` flag goes to 1.
- R4: A low level on `in_strb_ni` or `out_strb_ni` at either of the first two clock edges that sample reset low sets `timing_err_o`. A strobe at those edges loads nothing.
- R5: `timing_err_o` also goes to 1 when reset is sampled high at the first clock edge after the sixth byte was loaded.
- R6: `ready_o` is 1 only when all six bytes were loaded and reset has been sampled high at two or more consecutive edges. Strobe edges sampled before `ready_o` is 1 produce no data write.
- R7: When reset is released with fewer than six bytes loaded, `incomplete_o` goes to 1 and `ready_o` stays 0.
- R8: While reset is high, the setting registers do not change, whatever the strobe and data inputs do.
- R9: The first edge that samples reset low opens a new window. It clears the load position and all three flags, so a full reload of six bytes is needed again.
- R10: A strobe edge accepted while ready gives a one-clock `data_we_o` pulse one clock later, with the data bus byte on `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low codec reset; low level is the load window |
| in_strb_ni | input | 1 | Active-low input data strobe |
| out_strb_ni | input | 1 | Active-low output strobe, watched for timing only |
| data_i | input | DATA_W | Data bus |
| erasure_mult_o | output | DATA_W | Setting slot 0 |
| err_thresh_o | output | DATA_W | Setting slot 1 |
| check_cnt_o | output | DATA_W | Setting slot 2 |
| msg_cnt_o | output | DATA_W | Setting slot 3 |
| blk_len_o | output | DATA_W | Setting slot 4 |
| ctrl_o | output | DATA_W | Setting slot 5 |
| ready_o | output | 1 | Configured and released long enough |
| data_we_o | output | 1 | Datapath byte write pulse |
| data_o | output | DATA_W | Byte for the datapath |
| overflow_o | output | 1 | Sticky: surplus strobes in the window |
| timing_err_o | output | 1 | Sticky: reset hold rule broken |
| incomplete_o | output | 1 | Sticky: released with fewer than six bytes |

## Verification
Each result has a fixed latency. A setting byte, `overflow_o` and the early-strobe flag appear one clock after the edge that samples the strobe. `incomplete_o` and the late-release flag appear one clock after the first edge that samples reset high. `ready_o` appears after the second high edge, and `data_we_o`/`data_o` appear one clock after the accepted strobe edge. The bench changes inputs on the falling clock edge and reads outputs at the next falling edge, so each check falls in the half cycle after the register that feeds it has updated. Checks that a strobe was blocked or ignored read the register outputs and `data_we_o` in that same window.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;
  localparam int unsigned CFG_REGS = 6;
  localparam int unsigned IDX_W    = $clog2(CFG_REGS + 1);
  typedef logic [IDX_W-1:0] slot_t;
  // slot order is the load order
  localparam int unsigned SLOT_ERAS   = 0;
  localparam int unsigned SLOT_THRESH = 1;
  localparam int unsigned SLOT_CHECK  = 2;
  localparam int unsigned SLOT_MSG    = 3;
  localparam int unsigned SLOT_BLEN   = 4;
  localparam int unsigned SLOT_CTRL   = 5;
endpackage

// File: rtl/codec_cfg_rst_timer.sv
module codec_cfg_rst_timer #(
  parameter int unsigned HOLD_LOW  = 2,
  parameter int unsigned HOLD_HIGH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_strb_ni,
  input  logic out_strb_ni,
  output logic win_open_o,
  output logic pre_ok_o,
  output logic rise_o,
  output logic high_ok_o,
  output logic fire_o,
  output logic early_o
);
  localparam int unsigned HOLD_MAX = (HOLD_LOW > HOLD_HIGH) ? HOLD_LOW : HOLD_HIGH;
  localparam int unsigned CNT_W    = $clog2(HOLD_MAX + 1);
  localparam logic [CNT_W-1:0] SAT      = CNT_W'(HOLD_MAX);
  localparam logic [CNT_W-1:0] LOW_LIM  = CNT_W'(HOLD_LOW);
  localparam logic [CNT_W-1:0] HIGH_LIM = CNT_W'(HOLD_HIGH);

  logic [CNT_W-1:0] low_cnt_q, high_cnt_q;
  logic             strb_q;

  // rst_ni is sampled: its low phase is a working window, not a clear
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      high_cnt_q <= '0;
      if (low_cnt_q != SAT) low_cnt_q <= low_cnt_q + 1'b1;
    end else begin
      low_cnt_q <= '0;
      if (high_cnt_q != SAT) high_cnt_q <= high_cnt_q + 1'b1;
    end
    strb_q <= in_strb_ni;
  end

  assign win_open_o = !rst_ni && (low_cnt_q == '0);
  assign pre_ok_o   = low_cnt_q >= LOW_LIM;
  assign rise_o     = rst_ni && (low_cnt_q != '0);
  assign high_ok_o  = high_cnt_q >= HIGH_LIM;
  assign fire_o     = strb_q && !in_strb_ni;
  assign early_o    = !rst_ni && !pre_ok_o && (!in_strb_ni || !out_strb_ni);
endmodule

// File: rtl/codec_cfg_load_seq.sv
module codec_cfg_load_seq
  import codec_cfg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  win_open_i,
  input  logic  pre_ok_i,
  input  logic  rise_i,
  input  logic  fire_i,
  input  logic  early_i,
  output slot_t slot_o,
  output logic  load_o,
  output logic  full_o,
  output logic  overflow_o,
  output logic  timing_err_o,
  output logic  incomplete_o
);
  localparam slot_t FULL = IDX_W'(CFG_REGS);
  localparam slot_t LAST = IDX_W'(CFG_REGS - 1);

  slot_t slot_q;
  logic  last_q, ovf_q, terr_q, inc_q;
  logic  strb_ok;

  assign strb_ok = !rst_ni && pre_ok_i && fire_i;
  assign load_o  = strb_ok && (slot_q != FULL);
  assign full_o  = slot_q == FULL;

  always_ff @(posedge clk_i) begin
    last_q <= load_o && (slot_q == LAST);
    if (win_open_i) begin
      slot_q <= '0;
      ovf_q  <= 1'b0;
      inc_q  <= 1'b0;
      terr_q <= early_i;
    end else begin
      if (load_o)                 slot_q <= slot_q + 1'b1;
      if (strb_ok && full_o)      ovf_q  <= 1'b1;
      if (early_i)                terr_q <= 1'b1;
      if (rise_i && last_q)       terr_q <= 1'b1;  // released right after byte six
      if (rise_i && !full_o)      inc_q  <= 1'b1;
    end
  end

  assign slot_o       = slot_q;
  assign overflow_o   = ovf_q;
  assign timing_err_o = terr_q;
  assign incomplete_o = inc_q;
endmodule

// File: rtl/codec_cfg_regfile.sv
module codec_cfg_regfile
  import codec_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                               clk_i,
  input  logic                               load_i,
  input  slot_t                              slot_i,
  input  logic [DATA_W-1:0]                  data_i,
  output logic [CFG_REGS-1:0][DATA_W-1:0]    regs_o
);
  for (genvar g = 0; g < CFG_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (load_i && (slot_i == IDX_W'(g))) q <= data_i;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/codec_cfg_loader.sv
module codec_cfg_loader
  import codec_cfg_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HOLD_LOW  = 2,
  parameter int unsigned HOLD_HIGH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_strb_ni,
  input  logic              out_strb_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] erasure_mult_o,
  output logic [DATA_W-1:0] err_thresh_o,
  output logic [DATA_W-1:0] check_cnt_o,
  output logic [DATA_W-1:0] msg_cnt_o,
  output logic [DATA_W-1:0] blk_len_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              ready_o,
  output logic              data_we_o,
  output logic [DATA_W-1:0] data_o,
  output logic              overflow_o,
  output logic              timing_err_o,
  output logic              incomplete_o
);
  logic  win_open, pre_ok, rise, high_ok, fire, early;
  logic  load, full;
  slot_t slot;
  logic [CFG_REGS-1:0][DATA_W-1:0] cfg_q;
  logic              we_q;
  logic [DATA_W-1:0] dat_q;
  logic              accept;

  codec_cfg_rst_timer #(.HOLD_LOW(HOLD_LOW), .HOLD_HIGH(HOLD_HIGH)) u_timer (
    .clk_i, .rst_ni, .in_strb_ni, .out_strb_ni,
    .win_open_o(win_open), .pre_ok_o(pre_ok), .rise_o(rise),
    .high_ok_o(high_ok), .fire_o(fire), .early_o(early)
  );

  codec_cfg_load_seq u_seq (
    .clk_i, .rst_ni,
    .win_open_i(win_open), .pre_ok_i(pre_ok), .rise_i(rise),
    .fire_i(fire), .early_i(early),
    .slot_o(slot), .load_o(load), .full_o(full),
    .overflow_o, .timing_err_o, .incomplete_o
  );

  codec_cfg_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .load_i(load), .slot_i(slot), .data_i, .regs_o(cfg_q)
  );

  assign ready_o = full && high_ok;
  assign accept  = rst_ni && fire && ready_o;

  always_ff @(posedge clk_i) begin
    we_q <= accept;
    if (accept) dat_q <= data_i;
  end

  assign data_we_o      = we_q;
  assign data_o         = dat_q;
  assign erasure_mult_o = cfg_q[SLOT_ERAS];
  assign err_thresh_o   = cfg_q[SLOT_THRESH];
  assign check_cnt_o    = cfg_q[SLOT_CHECK];
  assign msg_cnt_o      = cfg_q[SLOT_MSG];
  assign blk_len_o      = cfg_q[SLOT_BLEN];
  assign ctrl_o         = cfg_q[SLOT_CTRL];
endmodule

// File: rtl/codec_cfg_loader_chk.sv
module codec_cfg_loader_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              data_we_o,
  input logic              overflow_o,
  input logic              incomplete_o,
  input logic [DATA_W-1:0] erasure_mult_o,
  input logic [DATA_W-1:0] err_thresh_o,
  input logic [DATA_W-1:0] check_cnt_o,
  input logic [DATA_W-1:0] msg_cnt_o,
  input logic [DATA_W-1:0] blk_len_o,
  input logic [DATA_W-1:0] ctrl_o
);
  assert_ready_after_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ($past(rst_ni) && $past(rst_ni, 2)));

  assert_write_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o |-> ($past(ready_o) && $past(rst_ni)));

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable({erasure_mult_o, err_thresh_o, check_cnt_o,
                               msg_cnt_o, blk_len_o, ctrl_o}));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> !$past(rst_ni));

  assert_incomplete_at_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(incomplete_o) |-> !$past(rst_ni, 2));

  assert_ready_complete_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !incomplete_o);
endmodule

bind codec_cfg_loader codec_cfg_loader_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/codec_cfg_loader_tb.sv
`timescale 1ns/1ps
module codec_cfg_loader_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       in_strb_ni = 1'b1;
  logic       out_strb_ni = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic [7:0] era, thr, chk, msg, blen, ctl, dat;
  logic       ready, we, ovf, terr, inc;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  codec_cfg_loader u_dut (
    .clk_i, .rst_ni, .in_strb_ni, .out_strb_ni, .data_i,
    .erasure_mult_o(era), .err_thresh_o(thr), .check_cnt_o(chk),
    .msg_cnt_o(msg), .blk_len_o(blen), .ctrl_o(ctl),
    .ready_o(ready), .data_we_o(we), .data_o(dat),
    .overflow_o(ovf), .timing_err_o(terr), .incomplete_o(inc)
  );

  // {strobe count[3:0], bytes slot5..slot0 [47:0], exp ready, exp ovf, exp incomplete}
  localparam logic [54:0] VECS [4] = '{
    {4'd6, 48'h665544332211, 3'b100},
    {4'd8, 48'hF0E1D2C3B4A5, 3'b110},
    {4'd3, 48'h000000_0C0B0A, 3'b001},
    {4'd6, 48'h5A4B3C2D1E0F, 3'b100}
  };

  task automatic tick(); @(negedge clk_i); endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg_at(int k);
    case (k)
      0: return era; 1: return thr; 2: return chk;
      3: return msg; 4: return blen; default: return ctl;
    endcase
  endfunction

  task automatic open_window();
    rst_ni = 1'b0; tick(); tick();
  endtask

  task automatic strobe(logic [7:0] b);
    in_strb_ni = 1'b0; data_i = b; tick();
    in_strb_ni = 1'b1; tick();
  endtask

  task automatic close_window();
    rst_ni = 1'b1; tick(); tick();
  endtask

  task automatic load_six(logic [7:0] base);
    for (int k = 0; k < 6; k++) strobe(base + 8'(k));
  endtask

  initial begin
    tick(); tick();
    // reset state inside a fresh window (R9)
    open_window();
    check("R9 ready in window", {7'd0, ready}, 8'd0);
    check("R9 ovf cleared", {7'd0, ovf}, 8'd0);
    check("R9 terr cleared", {7'd0, terr}, 8'd0);
    check("R9 inc cleared", {7'd0, inc}, 8'd0);
    check("R10 no write in window", {7'd0, we}, 8'd0);
    rst_ni = 1'b1; tick(); tick();

    // table walk: R1 R3 R6 R7 R9
    for (int v = 0; v < 4; v++) begin
      logic [3:0]  n;
      logic [47:0] bytes;
      n = VECS[v][54:51];
      bytes = VECS[v][50:3];
      open_window();
      for (int k = 0; k < int'(n); k++)
        strobe(k < 6 ? bytes[8*k +: 8] : 8'hE0 + 8'(k));
      rst_ni = 1'b1; tick();
      check("R6 not ready after one high edge", {7'd0, ready}, 8'd0);
      tick();
      for (int k = 0; k < 6; k++)
        if (k < int'(n)) check("R1 slot value", cfg_at(k), bytes[8*k +: 8]);
      check("R6 ready", {7'd0, ready}, {7'd0, VECS[v][2]});
      check("R3 overflow", {7'd0, ovf}, {7'd0, VECS[v][1]});
      check("R7 incomplete", {7'd0, inc}, {7'd0, VECS[v][0]});
      check("R5 no timing error", {7'd0, terr}, 8'd0);
    end

    // R6 gating and R10 write pulse, R8 hold
    open_window();
    load_six(8'h40);
    rst_ni = 1'b1; in_strb_ni = 1'b0; data_i = 8'h77; tick();
    in_strb_ni = 1'b1;
    check("R6 strobe blocked at first high edge", {7'd0, we}, 8'd0);
    tick();
    check("R6 ready after two high edges", {7'd0, ready}, 8'd1);
    in_strb_ni = 1'b0; data_i = 8'h5A; tick();
    check("R10 write pulse", {7'd0, we}, 8'd1);
    check("R10 write data", dat, 8'h5A);
    in_strb_ni = 1'b1; tick();
    check("R10 single pulse", {7'd0, we}, 8'd0);
    check("R8 slot0 held", era, 8'h40);
    check("R8 slot5 held", ctl, 8'h45);
    in_strb_ni = 1'b0; data_i = 8'hC3; tick(); in_strb_ni = 1'b1; tick();
    check("R8 slot1 held", thr, 8'h41);

    // R4 input strobe too early: not loaded, flag set
    rst_ni = 1'b0; in_strb_ni = 1'b0; data_i = 8'h99; tick();
    in_strb_ni = 1'b1; tick();
    load_six(8'h60);
    close_window();
    check("R4 early in-strobe flag", {7'd0, terr}, 8'd1);
    check("R4 early byte not loaded", era, 8'h60);
    check("R4 ready still", {7'd0, ready}, 8'd1);

    // R4 output strobe low during hold
    rst_ni = 1'b0; tick();
    check("R9 terr cleared at window open", {7'd0, terr}, 8'd0);
    out_strb_ni = 1'b0; tick();
    out_strb_ni = 1'b1;
    check("R4 early out-strobe flag", {7'd0, terr}, 8'd1);
    load_six(8'h70);
    close_window();
    check("R4 flag sticky", {7'd0, terr}, 8'd1);

    // R2 long pulse loads once
    open_window();
    in_strb_ni = 1'b0; data_i = 8'h11; tick(); tick(); tick();
    in_strb_ni = 1'b1; tick();
    for (int k = 1; k < 6; k++) strobe(8'h20 + 8'(k));
    close_window();
    check("R2 long pulse slot0", era, 8'h11);
    check("R2 next byte slot1", thr, 8'h21);
    check("R2 slot5", ctl, 8'h25);
    check("R2 no overflow", {7'd0, ovf}, 8'd0);
    check("R2 ready", {7'd0, ready}, 8'd1);

    // R5 release right after sixth byte
    open_window();
    for (int k = 0; k < 5; k++) strobe(8'h80 + 8'(k));
    in_strb_ni = 1'b0; data_i = 8'h85; tick();
    in_strb_ni = 1'b1; rst_ni = 1'b1; tick();
    check("R5 late release flag", {7'd0, terr}, 8'd1);
    tick();
    check("R5 slot5 loaded", ctl, 8'h85);
    check("R5 ready", {7'd0, ready}, 8'd1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule